// File: doc/BRIEF.md
# In-Band Scan Configuration Loader

This block takes the routing configuration for an on-chip scan router out of the scan data stream itself, so no slow side network is needed to reconfigure the router between patterns. On every tester channel the first few shift cycles of each pattern load a small per-channel control shift register. The shift cycles that follow pass straight through to the core-side data path.

When the tester raises the end-of-load strobe, all control registers are copied at once into a shadow register, and the shadow register drives the router address lines. A configuration therefore takes effect one pattern after the pattern that carried it. For this reason the first vector of a test set only carries configuration, and every pattern repeats the control bits of the configuration in force after it. The control field is short compared with the full shift length of a pattern.

Top module: `cfg_inband_loader`

## Requirements
- R1: While rst_ni is low and after it is released, cfg_o is all zero (no route), and the next shift cycle is the first control cycle of a pattern.
- R2: In the first CTRL_BITS shift cycles (scan_en_i high) after reset or after a strobe, core_vld_o is low and core_o is all zero.
- R3: In every later shift cycle of the same pattern, core_vld_o is high and core_o equals chan_i in the same cycle.
- R4: Control bits enter most significant bit first. The bit on channel c in control cycle j (0-based) ends in cfg_o bit c*CTRL_BITS + (CTRL_BITS-1-j).
- R5: cfg_o changes only in the clock after a cycle with load_done_i high, and holds its value through all shift and idle cycles.
- R6: One strobe copies the whole control value of all channels in a single clock, so the value shifted during pattern n drives cfg_o for the whole of pattern n+1.
- R7: If the strobe falls in the same cycle as a shift, that shift bit belongs to the ending pattern. When that cycle is a control cycle, its bit is part of the captured value, and the next shift starts a new control window.
- R8: A cycle with scan_en_i low neither advances the control window nor changes the control register, and it drives core_vld_o low.
- R9: Data-cycle bits never change the control register. The value captured from a pattern longer than CTRL_BITS is set by its first CTRL_BITS shift bits only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scan_en_i | input | 1 | Shift enable; one tester bit per channel is consumed per cycle |
| load_done_i | input | 1 | End-of-pattern-load strobe |
| chan_i | input | NUM_CH | Serial tester channel bits |
| core_o | output | NUM_CH | Channel bits forwarded to the core path (zero outside data cycles) |
| core_vld_o | output | 1 | core_o carries test data this cycle |
| cfg_o | output | NUM_CH*CTRL_BITS | Shadowed router configuration, channel c in bits [c*CTRL_BITS +: CTRL_BITS] |

## Verification
The end-of-load strobe and a shift can fall in the same cycle. The shift may then be a data bit, or the last control bit of a pattern that is exactly CTRL_BITS long. The bench sweeps every configuration value of a 4-channel, 3-bit setup. It mixes patterns whose strobe coincides with the final shift with patterns that strobe in a separate idle cycle. In each case it judges the result by checking that cfg_o, one clock after the strobe, equals the value streamed in that pattern and nothing else. It also checks that the following pattern starts with a fresh control window.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic {
    PH_CTRL = 1'b0,
    PH_DATA = 1'b1
  } shift_phase_e;
endpackage

// File: rtl/cfg_win_ctr.sv
module cfg_win_ctr #(
  parameter int CTRL_BITS = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        shift_i,
  input  logic                        restart_i,
  output cfg_loader_pkg::shift_phase_e phase_o
);
  localparam int CW = $clog2(CTRL_BITS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CTRL_BITS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (shift_i && (cnt_q != LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = (cnt_q == LIMIT) ? cfg_loader_pkg::PH_DATA : cfg_loader_pkg::PH_CTRL;
endmodule

// File: rtl/cfg_chan_sr.sv
module cfg_chan_sr #(
  parameter int CTRL_BITS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shift_i,
  input  logic                 bit_i,
  output logic [CTRL_BITS-1:0] sr_nxt_o
);
  logic [CTRL_BITS-1:0] sr_q;

  generate
    if (CTRL_BITS == 1) begin : g_single
      assign sr_nxt_o = shift_i ? bit_i : sr_q;
    end else begin : g_multi
      // first bit received ends up in the MSB
      assign sr_nxt_o = shift_i ? {sr_q[CTRL_BITS-2:0], bit_i} : sr_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_nxt_o;
  end
endmodule

// File: rtl/cfg_shadow.sv
module cfg_shadow #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/cfg_inband_loader.sv
module cfg_inband_loader #(
  parameter int NUM_CH    = 4,
  parameter int CTRL_BITS = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          scan_en_i,
  input  logic                          load_done_i,
  input  logic [NUM_CH-1:0]             chan_i,
  output logic [NUM_CH-1:0]             core_o,
  output logic                          core_vld_o,
  output logic [NUM_CH*CTRL_BITS-1:0]   cfg_o
);
  localparam int CFG_W = NUM_CH * CTRL_BITS;

  cfg_loader_pkg::shift_phase_e phase;
  logic                         ctrl_shift;
  logic [CFG_W-1:0]             sr_nxt;

  cfg_win_ctr #(.CTRL_BITS(CTRL_BITS)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shift_i  (scan_en_i),
    .restart_i(load_done_i),
    .phase_o  (phase)
  );

  assign ctrl_shift = scan_en_i && (phase == cfg_loader_pkg::PH_CTRL);
  assign core_vld_o = scan_en_i && (phase == cfg_loader_pkg::PH_DATA);
  assign core_o     = chan_i & {NUM_CH{core_vld_o}};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cfg_chan_sr #(.CTRL_BITS(CTRL_BITS)) u_sr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .shift_i (ctrl_shift),
      .bit_i   (chan_i[c]),
      .sr_nxt_o(sr_nxt[c*CTRL_BITS +: CTRL_BITS])
    );
  end

  // capture the post-shift value so a coincident control bit is included
  cfg_shadow #(.W(CFG_W)) u_shadow (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_done_i),
    .d_i   (sr_nxt),
    .q_o   (cfg_o)
  );
endmodule

// File: rtl/cfg_inband_loader_chk.sv
module cfg_inband_loader_chk #(
  parameter int NUM_CH    = 4,
  parameter int CTRL_BITS = 3
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        scan_en_i,
  input logic                        load_done_i,
  input logic [NUM_CH-1:0]           chan_i,
  input logic [NUM_CH-1:0]           core_o,
  input logic                        core_vld_o,
  input logic [NUM_CH*CTRL_BITS-1:0] cfg_o
);
  int unsigned seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             seen_q <= 0;
    else if (load_done_i)    seen_q <= 0;
    else if (scan_en_i && seen_q < CTRL_BITS) seen_q <= seen_q + 1;
  end

  a_r2_ctrl_hidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_en_i && seen_q < CTRL_BITS) |-> (!core_vld_o && core_o == '0));

  a_r3_data_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_en_i && seen_q >= CTRL_BITS) |-> (core_vld_o && core_o == chan_i));

  a_r5_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_done_i |=> $stable(cfg_o));

  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_en_i |-> (!core_vld_o && core_o == '0));

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (cfg_o == '0));
endmodule

bind cfg_inband_loader cfg_inband_loader_chk #(
  .NUM_CH(NUM_CH), .CTRL_BITS(CTRL_BITS)
) u_chk (.*);

// File: tb/cfg_inband_loader_tb.sv
module cfg_inband_loader_tb;
  localparam int NUM_CH    = 4;
  localparam int CTRL_BITS = 3;
  localparam int W         = NUM_CH * CTRL_BITS;
  localparam int NPAT      = 1 << W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              scan_en = 1'b0;
  logic              load_done = 1'b0;
  logic [NUM_CH-1:0] chan = '0;
  logic [NUM_CH-1:0] core;
  logic              core_vld;
  logic [W-1:0]      cfg;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_cfg = '0;
  logic [W-1:0] cur_v = '0;

  always #2.5 clk = ~clk;

  cfg_inband_loader #(.NUM_CH(NUM_CH), .CTRL_BITS(CTRL_BITS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scan_en_i(scan_en), .load_done_i(load_done),
    .chan_i(chan), .core_o(core), .core_vld_o(core_vld), .cfg_o(cfg)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic do_cycle(input logic en, input logic [NUM_CH-1:0] d, input logic ld,
                          input logic exp_vld, input string cfg_tag);
    @(negedge clk);
    scan_en = en; chan = d; load_done = ld;
    #1;
    check(exp_vld ? "R3 vld" : "R2/R8 vld", W'(core_vld), W'(exp_vld));
    check(exp_vld ? "R3 data" : "R2/R8 data", W'(core), exp_vld ? W'(d) : '0);
    @(posedge clk);
    #1;
    if (ld) exp_cfg = cur_v;
    check(cfg_tag, cfg, exp_cfg);
  endtask

  task automatic run_pattern(input int p);
    int ndata, idle_at, total;
    bit coincide;
    logic [NUM_CH-1:0] d;
    string tag;
    cur_v   = W'(p * 1031);
    ndata   = p % 4;
    idle_at = (p % 5 == 0) ? 1 : -1;
    coincide = (p % 3 != 0);
    total   = CTRL_BITS + ndata;
    for (int s = 0; s < total; s++) begin
      if (s == idle_at) do_cycle(1'b0, '1, 1'b0, 1'b0, "R8 idle R5");
      for (int c = 0; c < NUM_CH; c++)
        d[c] = (s < CTRL_BITS) ? cur_v[c*CTRL_BITS + CTRL_BITS - 1 - s] : 1'(p + s + c);
      tag = (coincide && s == total - 1) ? ((s < CTRL_BITS) ? "R7 ctrl coincide R4" : "R7 data coincide R9")
                                         : "R5 hold";
      do_cycle(1'b1, d, coincide && (s == total - 1), s >= CTRL_BITS, tag);
    end
    if (!coincide) do_cycle(1'b0, '0, 1'b1, 1'b0, "R6 strobe R4 R9");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset cfg", cfg, '0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 cfg after release", cfg, '0);
    // config-only first vector, then every pattern carries the next config
    for (int p = 0; p < NPAT; p++) run_pattern(p);
    do_cycle(1'b0, '0, 1'b0, 1'b0, "R5 final hold");
    report();
  end
endmodule